// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Tracker

This block observes the command stream that a memory controller issues to an SDRAM, one registered command per clock, and keeps a model of every bank: idle, row open, reading, writing or precharging. It follows the single burst that owns the data bus beat by beat. It also times each bank's precharge separately, so that the controller or a checker beside it can see when a bank becomes usable again.

The central case is an access to one bank that cuts short a burst with auto-precharge on another bank. The tracker ends the old burst at the cycle the new READ or WRITE is registered. It starts the old bank's precharge on that same clock, and it reshapes the expected read-data stream to match. A WRITE that cuts into read data must be preceded by data masking. The tracker reports where masking was needed and whether the controller actually applied it two clocks earlier. Commands that break the bank rules are flagged and otherwise ignored.

Top module: `sdram_cap_tracker`

## Requirements
- R1: After reset every bank reads as idle and rd_valid, dqm_req, dqm_err and cmd_illegal are low.
- R2: Command codes on cmd are 0 no-op, 1 open row, 2 read, 3 write, 4 precharge. Bank codes in bank_state (3 bits per bank, bank b at bits 3b+2..3b) are 0 idle, 1 row open, 2 reading, 3 writing, 4 precharging. Opening a row on an idle bank makes it code 1. A precharge to a bank in code 1 makes it code 4. A precharge to an idle or precharging bank is legal and changes nothing.
- R3: Each of the following raises cmd_illegal on the clock after it is registered and changes no bank state: opening a row on a bank that is not idle; a read or write to an idle or precharging bank; a precharge to a bank in code 2 or 3; a read or write to the bank whose burst has auto-precharge set.
- R4: A legal read or write registered at edge k holds its bank in code 2 or 3 until edge k+BL. At that edge the bank goes to code 1, or to code 4 when auto-precharge was set. cfg_bl codes 0, 1, 2, 3 give BL 1, 2, 4, 8.
- R5: Beat i of a read registered at edge k is shown on rd_valid, rd_bank and rd_col right after edge k+CL-1+i. rd_col is the start column plus i, modulo 2 to the power of the column width. cfg_cl 0 gives CL 2 and 1 gives CL 3.
- R6: A bank that enters code 4 at edge p returns to idle at edge p+cfg_trp, where a cfg_trp of 0 counts as 1. Each bank keeps its own count.
- R7: A legal read to another bank replaces the undelivered beats of the running burst, and its own beats follow with no gap. If the replaced burst had auto-precharge, that bank enters code 4 at the edge that registers the new read.
- R8: A legal write ends any read burst at the edge it is registered. Read beats still in flight are discarded, so rd_valid stays low. An interrupted bank with auto-precharge enters code 4 on that edge.
- R9: A legal write registered while a read burst still has beats to issue, or while read beats are in flight, pulses dqm_req on the next clock. dqm_err pulses with it when dqm_in, sampled two edges before the write, was low.
- R10: With cfg_cap_en low, a read or write to another bank while an auto-precharge burst still has beats to issue is illegal. The running burst then continues unchanged.
- R11: At most one bank is in code 2 or 3 at any time. A non-auto-precharge burst that is cut short returns its bank to code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bl | input | 2 | Burst length code |
| cfg_cl | input | 1 | CAS latency select (0: 2, 1: 3) |
| cfg_trp | input | TRP_W | Precharge time in clocks |
| cfg_cap_en | input | 1 | Allow accesses that interrupt auto-precharge bursts |
| cmd | input | 3 | Registered command code |
| cmd_bank | input | BANK_W | Target bank |
| cmd_col | input | COL_W | Start column of an access |
| cmd_ap | input | 1 | Auto-precharge on this access |
| dqm_in | input | 1 | Data mask as driven by the controller |
| bank_state | output | 3*NUM_BANKS | Per-bank state codes |
| rd_valid | output | 1 | A read beat is expected on the bus |
| rd_bank | output | BANK_W | Bank of that beat |
| rd_col | output | COL_W | Column of that beat |
| dqm_req | output | 1 | A write needed masking ahead of it |
| dqm_err | output | 1 | That masking was missing |
| cmd_illegal | output | 1 | Previous command broke a bank rule |

## Verification
A walked sequence of open, read, write and precharge commands on two banks checks the legal transitions against every illegal one, each judged on both the flag and the target bank's code. Directed bursts then separate the natural end of an auto-precharge burst from an end forced by a read to another bank or by a write. The two are told apart by the edge on which the old bank enters precharge and by which beats appear on the read outputs. Running the same interruption with concurrent support off, and the write interruption with masking present and absent, checks the two flags. A burst of two at latency two that starts on the last column checks the other latency, the column wrap and a longer precharge time.

// File: rtl/sdram_cap_pkg.sv
package sdram_cap_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } cmd_e;

   typedef enum logic [2:0] {
      BK_IDLE   = 3'd0,
      BK_ACTIVE = 3'd1,
      BK_READ   = 3'd2,
      BK_WRITE  = 3'd3,
      BK_PRE    = 3'd4
   } bank_st_e;

   localparam int unsigned MAX_CL = 3;

endpackage

// File: rtl/sdram_cap_bank.sv
module sdram_cap_bank
   import sdram_cap_pkg::*;
#(
   parameter int TRP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_act,
   input  logic             go_rd,
   input  logic             go_wr,
   input  logic             go_pre,
   input  logic             go_end,
   input  logic [TRP_W-1:0] cfg_trp,
   output bank_st_e         st
);

   logic [TRP_W-1:0] pre_cnt;
   logic [TRP_W-1:0] trp_eff;

   assign trp_eff = (cfg_trp == '0) ? TRP_W'(1) : cfg_trp;

   // Priority: a new access wins over the end of an older burst on this bank.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= BK_IDLE;
         pre_cnt <= '0;
      end else if (go_rd) begin
         st <= BK_READ;
      end else if (go_wr) begin
         st <= BK_WRITE;
      end else if (go_pre) begin
         st      <= BK_PRE;
         pre_cnt <= trp_eff;
      end else if (go_act || go_end) begin
         st <= BK_ACTIVE;
      end else if (st == BK_PRE) begin
         if (pre_cnt <= TRP_W'(1)) begin
            st      <= BK_IDLE;
            pre_cnt <= '0;
         end else begin
            pre_cnt <= pre_cnt - TRP_W'(1);
         end
      end
   end

   // An idle bank only leaves idle through a row open.
   assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_IDLE && !go_act) |=> st == BK_IDLE);

   // A precharging bank either keeps counting or becomes idle.
   assert_pre_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_PRE) |=> (st == BK_PRE || st == BK_IDLE));

endmodule

// File: rtl/sdram_cap_burst.sv
module sdram_cap_burst #(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_bl,
   input  logic              start,
   input  logic              start_wr,
   input  logic              start_ap,
   input  logic [BANK_W-1:0] start_bank,
   input  logic [COL_W-1:0]  start_col,
   output logic              act,
   output logic [BANK_W-1:0] bank,
   output logic              wr,
   output logic              ap,
   output logic              left_nz,
   output logic              fin,
   output logic              inj_v,
   output logic [COL_W-1:0]  inj_col
);

   logic [2:0]       left;
   logic [2:0]       beat;
   logic [COL_W-1:0] base;
   logic [2:0]       blen_m1;

   assign blen_m1 = 3'((4'd1 << cfg_bl) - 4'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act  <= 1'b0;
         left <= '0;
         beat <= '0;
         bank <= '0;
         wr   <= 1'b0;
         ap   <= 1'b0;
         base <= '0;
      end else if (start) begin
         act  <= 1'b1;
         left <= blen_m1;
         beat <= 3'd1;
         bank <= start_bank;
         wr   <= start_wr;
         ap   <= start_ap;
         base <= start_col;
      end else if (act) begin
         if (left != 3'd0) begin
            left <= left - 3'd1;
            beat <= beat + 3'd1;
         end else begin
            act <= 1'b0;
         end
      end
   end

   assign left_nz = (left != 3'd0);
   // The burst ends at its natural last edge, or when replaced by a new access.
   assign fin     = act && (!left_nz || start);
   assign inj_v   = act && !wr && left_nz && !start;
   assign inj_col = base + COL_W'(beat);

   // A running burst never counts more beats than the longest burst.
   assert_beat_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (32'(beat) + 32'(left)) <= 32'd8);

endmodule

// File: rtl/sdram_cap_rdpipe.sv
module sdram_cap_rdpipe
   import sdram_cap_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cl,
   input  logic              inj_v,
   input  logic [BANK_W-1:0] inj_bank,
   input  logic [COL_W-1:0]  inj_col,
   input  logic              flush,
   output logic              out_v,
   output logic [BANK_W-1:0] out_bank,
   output logic [COL_W-1:0]  out_col,
   output logic              pend
);

   localparam int DEPTH = MAX_CL;

   logic [DEPTH-1:0]  v;
   logic [BANK_W-1:0] b_q [DEPTH];
   logic [COL_W-1:0]  c_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         v <= '0;
      end else begin
         v <= {v[DEPTH-2:0], inj_v};
      end
   end

   always_ff @(posedge clk) begin
      b_q[0] <= inj_bank;
      c_q[0] <= inj_col;
   end

   for (genvar g = 1; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
         b_q[g] <= b_q[g-1];
         c_q[g] <= c_q[g-1];
      end
   end

   // Output tap sits at stage CL-1.
   assign out_v    = cfg_cl ? v[2]   : v[1];
   assign out_bank = cfg_cl ? b_q[2] : b_q[1];
   assign out_col  = cfg_cl ? c_q[2] : c_q[1];
   assign pend     = cfg_cl ? (|v[2:0]) : (|v[1:0]);

   // Discarded beats never reach the output.
   assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_v);

endmodule

// File: rtl/sdram_cap_tracker.sv
module sdram_cap_tracker
   import sdram_cap_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int COL_W     = 9,
   parameter int TRP_W     = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             cfg_bl,
   input  logic                   cfg_cl,
   input  logic [TRP_W-1:0]       cfg_trp,
   input  logic                   cfg_cap_en,
   input  logic [2:0]             cmd,
   input  logic [BANK_W-1:0]      cmd_bank,
   input  logic [COL_W-1:0]       cmd_col,
   input  logic                   cmd_ap,
   input  logic                   dqm_in,
   output logic [3*NUM_BANKS-1:0] bank_state,
   output logic                   rd_valid,
   output logic [BANK_W-1:0]      rd_bank,
   output logic [COL_W-1:0]       rd_col,
   output logic                   dqm_req,
   output logic                   dqm_err,
   output logic                   cmd_illegal
);

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (COL_W < 3) begin : g_bad_col
      $error("COL_W must be at least 3");
   end
   if (TRP_W < 1) begin : g_bad_trp
      $error("TRP_W must be at least 1");
   end

   bank_st_e            st [NUM_BANKS];
   logic [NUM_BANKS-1:0] busy_vec;

   logic is_act, is_rd, is_wr, is_pre, is_rw;
   bank_st_e tgt;
   logic illegal_c, legal_rw, same;

   logic              b_act, b_wr, b_ap, b_left_nz, b_fin, b_inj_v;
   logic [BANK_W-1:0] b_bank;
   logic [COL_W-1:0]  b_inj_col;

   logic              inj_v, flush, pend;
   logic [BANK_W-1:0] inj_bank;
   logic [COL_W-1:0]  inj_col;
   logic              dqm_d1, dqm_d2, dqm_need;

   assign is_act = (cmd == CMD_ACT);
   assign is_rd  = (cmd == CMD_RD);
   assign is_wr  = (cmd == CMD_WR);
   assign is_pre = (cmd == CMD_PRE);
   assign is_rw  = is_rd || is_wr;
   assign tgt    = st[cmd_bank];
   assign same   = b_act && (b_bank == cmd_bank);

   always_comb begin
      illegal_c = 1'b0;
      if (is_act) begin
         illegal_c = (tgt != BK_IDLE);
      end else if (is_rw) begin
         illegal_c = (tgt == BK_IDLE) || (tgt == BK_PRE) || (same && b_ap) ||
                     (b_act && b_left_nz && b_ap && !same && !cfg_cap_en);
      end else if (is_pre) begin
         illegal_c = (tgt == BK_READ) || (tgt == BK_WRITE);
      end
   end

   assign legal_rw = is_rw && !illegal_c;

   sdram_cap_burst #(.BANK_W(BANK_W), .COL_W(COL_W)) burst_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_bl     (cfg_bl),
      .start      (legal_rw),
      .start_wr   (is_wr),
      .start_ap   (cmd_ap),
      .start_bank (cmd_bank),
      .start_col  (cmd_col),
      .act        (b_act),
      .bank       (b_bank),
      .wr         (b_wr),
      .ap         (b_ap),
      .left_nz    (b_left_nz),
      .fin        (b_fin),
      .inj_v      (b_inj_v),
      .inj_col    (b_inj_col)
   );

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic hit, go_act, go_rd, go_wr, go_pre, go_end, own;
      assign hit    = (cmd_bank == BANK_W'(gb));
      assign own    = (b_bank == BANK_W'(gb));
      assign go_act = is_act && !illegal_c && hit;
      assign go_rd  = legal_rw && is_rd && hit;
      assign go_wr  = legal_rw && is_wr && hit;
      assign go_pre = (is_pre && hit && st[gb] == BK_ACTIVE) ||
                      (b_fin && b_ap && own);
      assign go_end = b_fin && !b_ap && own;

      sdram_cap_bank #(.TRP_W(TRP_W)) bank_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .go_act  (go_act),
         .go_rd   (go_rd),
         .go_wr   (go_wr),
         .go_pre  (go_pre),
         .go_end  (go_end),
         .cfg_trp (cfg_trp),
         .st      (st[gb])
      );

      assign bank_state[3*gb +: 3] = st[gb];
      assign busy_vec[gb] = (st[gb] == BK_READ) || (st[gb] == BK_WRITE);
   end

   // A new read injects its first beat; otherwise the running read continues.
   assign inj_v    = (legal_rw && is_rd) || b_inj_v;
   assign inj_bank = (legal_rw && is_rd) ? cmd_bank : b_bank;
   assign inj_col  = (legal_rw && is_rd) ? cmd_col  : b_inj_col;
   assign flush    = legal_rw && is_wr;

   sdram_cap_rdpipe #(.BANK_W(BANK_W), .COL_W(COL_W)) rdpipe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_cl   (cfg_cl),
      .inj_v    (inj_v),
      .inj_bank (inj_bank),
      .inj_col  (inj_col),
      .flush    (flush),
      .out_v    (rd_valid),
      .out_bank (rd_bank),
      .out_col  (rd_col),
      .pend     (pend)
   );

   assign dqm_need = flush && (pend || (b_act && !b_wr && b_left_nz));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dqm_d1      <= 1'b0;
         dqm_d2      <= 1'b0;
         dqm_req     <= 1'b0;
         dqm_err     <= 1'b0;
         cmd_illegal <= 1'b0;
      end else begin
         dqm_d1      <= dqm_in;
         dqm_d2      <= dqm_d1;
         dqm_req     <= dqm_need;
         dqm_err     <= dqm_need && !dqm_d2;
         cmd_illegal <= illegal_c;
      end
   end

   assert_single_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy_vec));

   assert_intr_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_rw && b_act && b_ap && b_left_nz && !same)
      |=> bank_state[3*$past(b_bank) +: 3] == 3'd4);

   assert_cap_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && b_act && b_ap && b_left_nz && !same && !cfg_cap_en) |=> cmd_illegal);

   assert_dqm_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dqm_err |-> dqm_req);

endmodule

// File: tb/sdram_cap_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cap_tracker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_bl = 2'd0;
   logic        cfg_cl = 1'b0;
   logic [3:0]  cfg_trp = 4'd2;
   logic        cfg_cap_en = 1'b1;
   logic [2:0]  cmd = 3'd0;
   logic [1:0]  cmd_bank = 2'd0;
   logic [8:0]  cmd_col = 9'd0;
   logic        cmd_ap = 1'b0;
   logic        dqm_in = 1'b0;
   logic [11:0] bank_state;
   logic        rd_valid;
   logic [1:0]  rd_bank;
   logic [8:0]  rd_col;
   logic        dqm_req, dqm_err, cmd_illegal;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   sdram_cap_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
      .cfg_trp(cfg_trp), .cfg_cap_en(cfg_cap_en), .cmd(cmd),
      .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
      .dqm_in(dqm_in), .bank_state(bank_state), .rd_valid(rd_valid),
      .rd_bank(rd_bank), .rd_col(rd_col), .dqm_req(dqm_req),
      .dqm_err(dqm_err), .cmd_illegal(cmd_illegal)
   );

   // Entry: cmd[18:16] bank[15:14] col[13:5] ap[4] exp_illegal[3] exp_state[2:0]
   localparam int NVEC = 15;
   localparam logic [18:0] VEC [NVEC] = '{
      {3'd1, 2'd0, 9'd0, 1'b0, 1'b0, 3'd1},
      {3'd1, 2'd0, 9'd0, 1'b0, 1'b1, 3'd1},
      {3'd2, 2'd1, 9'd0, 1'b0, 1'b1, 3'd0},
      {3'd1, 2'd1, 9'd0, 1'b0, 1'b0, 3'd1},
      {3'd2, 2'd0, 9'd5, 1'b0, 1'b0, 3'd2},
      {3'd0, 2'd0, 9'd0, 1'b0, 1'b0, 3'd1},
      {3'd0, 2'd0, 9'd0, 1'b0, 1'b0, 3'd1},
      {3'd3, 2'd1, 9'd3, 1'b1, 1'b0, 3'd3},
      {3'd0, 2'd1, 9'd0, 1'b0, 1'b0, 3'd4},
      {3'd2, 2'd1, 9'd0, 1'b0, 1'b1, 3'd4},
      {3'd0, 2'd1, 9'd0, 1'b0, 1'b0, 3'd0},
      {3'd4, 2'd0, 9'd0, 1'b0, 1'b0, 3'd4},
      {3'd1, 2'd0, 9'd0, 1'b0, 1'b1, 3'd4},
      {3'd0, 2'd0, 9'd0, 1'b0, 1'b0, 3'd0},
      {3'd4, 2'd2, 9'd0, 1'b0, 1'b0, 3'd0}
   };

   function automatic logic [2:0] bst(input int b);
      return bank_state[3*b +: 3];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] c, input logic [1:0] b, input logic [8:0] col, input logic ap);
      cmd = c; cmd_bank = b; cmd_col = col; cmd_ap = ap;
      @(posedge clk);
      @(negedge clk);
      cmd = 3'd0; cmd_ap = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cmd = 3'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic chk_rd(input string req, input logic v, input logic [1:0] b, input logic [8:0] col);
      check({req, " rd_valid"}, 32'(rd_valid), 32'(v));
      if (v) begin
         check({req, " rd_bank"}, 32'(rd_bank), 32'(b));
         check({req, " rd_col"}, 32'(rd_col), 32'(col));
      end
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      for (int b = 0; b < 4; b++) check("R1 bank idle", 32'(bst(b)), 32'd0);
      check("R1 rd_valid", 32'(rd_valid), 32'd0);
      check("R1 dqm_req", 32'(dqm_req), 32'd0);
      check("R1 dqm_err", 32'(dqm_err), 32'd0);
      check("R1 cmd_illegal", 32'(cmd_illegal), 32'd0);

      // R2 R3 R4 R6: walked vector table, BL 1, CL 2, tRP 2
      cfg_bl = 2'd0; cfg_cl = 1'b0; cfg_trp = 4'd2; cfg_cap_en = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][18:16], VEC[i][15:14], VEC[i][13:5], VEC[i][4]);
         check($sformatf("R3 table[%0d] illegal", i), 32'(cmd_illegal), 32'(VEC[i][3]));
         check($sformatf("R2 table[%0d] state", i), 32'(bst(int'(VEC[i][15:14]))), 32'(VEC[i][2:0]));
         check($sformatf("R9 table[%0d] dqm_req", i), 32'(dqm_req), 32'd0);
      end

      // R4 R5 R6: uninterrupted read with auto-precharge, BL 4, CL 3
      do_reset();
      cfg_bl = 2'd2; cfg_cl = 1'b1; cfg_trp = 4'd2;
      apply(3'd1, 2'd0, 9'd0, 1'b0);
      apply(3'd2, 2'd0, 9'd8, 1'b1);
      check("R4 reading", 32'(bst(0)), 32'd2);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 before data", 1'b0, 2'd0, 9'd0);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 beat0", 1'b1, 2'd0, 9'd8);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 beat1", 1'b1, 2'd0, 9'd9);
      check("R4 still reading", 32'(bst(0)), 32'd2);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 beat2", 1'b1, 2'd0, 9'd10);
      check("R4 auto precharge at end", 32'(bst(0)), 32'd4);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 beat3", 1'b1, 2'd0, 9'd11);
      check("R6 precharging", 32'(bst(0)), 32'd4);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 after burst", 1'b0, 2'd0, 9'd0);
      check("R6 idle after tRP", 32'(bst(0)), 32'd0);

      // R7 R11: read interrupted by read on another bank
      do_reset();
      apply(3'd1, 2'd0, 9'd0, 1'b0);
      apply(3'd1, 2'd1, 9'd0, 1'b0);
      apply(3'd2, 2'd0, 9'd0, 1'b1);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      apply(3'd2, 2'd1, 9'd16, 1'b0);
      chk_rd("R7 old beat0", 1'b1, 2'd0, 9'd0);
      check("R7 old bank precharge at interrupt", 32'(bst(0)), 32'd4);
      check("R7 new bank reading", 32'(bst(1)), 32'd2);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R7 old beat1", 1'b1, 2'd0, 9'd1);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R7 new beat0", 1'b1, 2'd1, 9'd16);
      check("R6 interrupted bank idle", 32'(bst(0)), 32'd0);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R7 new beat1", 1'b1, 2'd1, 9'd17);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R7 new beat2", 1'b1, 2'd1, 9'd18);
      check("R4 new bank back to open", 32'(bst(1)), 32'd1);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R7 new beat3", 1'b1, 2'd1, 9'd19);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R7 end", 1'b0, 2'd0, 9'd0);
      // R11: a plain read cut short returns its bank to open
      apply(3'd1, 2'd2, 9'd0, 1'b0);
      apply(3'd2, 2'd1, 9'd0, 1'b0);
      apply(3'd2, 2'd2, 9'd0, 1'b0);
      check("R11 cut bank open", 32'(bst(1)), 32'd1);
      check("R11 new bank reading", 32'(bst(2)), 32'd2);

      // R8 R9: write interrupts read, mask present
      do_reset();
      dqm_in = 1'b1;
      apply(3'd1, 2'd0, 9'd0, 1'b0);
      apply(3'd1, 2'd1, 9'd0, 1'b0);
      apply(3'd2, 2'd0, 9'd0, 1'b1);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      apply(3'd3, 2'd1, 9'd4, 1'b0);
      check("R8 old bank precharge", 32'(bst(0)), 32'd4);
      check("R8 writing", 32'(bst(1)), 32'd3);
      check("R9 dqm_req", 32'(dqm_req), 32'd1);
      check("R9 dqm_err with mask", 32'(dqm_err), 32'd0);
      chk_rd("R8 flushed", 1'b0, 2'd0, 9'd0);
      for (int k = 0; k < 4; k++) begin
         apply(3'd0, 2'd0, 9'd0, 1'b0);
         chk_rd("R8 no read beats", 1'b0, 2'd0, 9'd0);
      end
      check("R9 dqm_req one pulse", 32'(dqm_req), 32'd0);

      // R9: same with mask missing
      do_reset();
      dqm_in = 1'b0;
      apply(3'd1, 2'd0, 9'd0, 1'b0);
      apply(3'd1, 2'd1, 9'd0, 1'b0);
      apply(3'd2, 2'd0, 9'd0, 1'b1);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      apply(3'd3, 2'd1, 9'd4, 1'b0);
      check("R9 dqm_req no mask", 32'(dqm_req), 32'd1);
      check("R9 dqm_err no mask", 32'(dqm_err), 32'd1);

      // R10: concurrent support off
      do_reset();
      cfg_cap_en = 1'b0;
      apply(3'd1, 2'd0, 9'd0, 1'b0);
      apply(3'd1, 2'd1, 9'd0, 1'b0);
      apply(3'd2, 2'd0, 9'd0, 1'b1);
      apply(3'd2, 2'd1, 9'd4, 1'b0);
      check("R10 illegal", 32'(cmd_illegal), 32'd1);
      check("R10 second bank unchanged", 32'(bst(1)), 32'd1);
      check("R10 burst continues", 32'(bst(0)), 32'd2);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R10 beat0", 1'b1, 2'd0, 9'd0);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R10 beat1 kept", 1'b1, 2'd0, 9'd1);
      cfg_cap_en = 1'b1;

      // R3: same-bank access and precharge during an auto-precharge burst
      do_reset();
      apply(3'd1, 2'd0, 9'd0, 1'b0);
      apply(3'd2, 2'd0, 9'd0, 1'b1);
      apply(3'd2, 2'd0, 9'd2, 1'b0);
      check("R3 same bank access illegal", 32'(cmd_illegal), 32'd1);
      apply(3'd4, 2'd0, 9'd0, 1'b0);
      check("R3 precharge during burst illegal", 32'(cmd_illegal), 32'd1);
      check("R3 burst state kept", 32'(bst(0)), 32'd2);

      // R4 R5 R6: BL 2, CL 2, column wrap, tRP 3
      do_reset();
      cfg_bl = 2'd1; cfg_cl = 1'b0; cfg_trp = 4'd3;
      apply(3'd1, 2'd3, 9'd0, 1'b0);
      apply(3'd2, 2'd3, 9'd511, 1'b1);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 CL2 beat0", 1'b1, 2'd3, 9'd511);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 CL2 beat1 wraps", 1'b1, 2'd3, 9'd0);
      check("R4 BL2 precharge", 32'(bst(3)), 32'd4);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      chk_rd("R5 CL2 end", 1'b0, 2'd0, 9'd0);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      check("R6 tRP3 still precharging", 32'(bst(3)), 32'd4);
      apply(3'd0, 2'd0, 9'd0, 1'b0);
      check("R6 tRP3 idle", 32'(bst(3)), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule